// File: doc/BRIEF.md
# Storage Fault Exception Router

This block takes a one-cycle report of an address translation fault and turns it into a classified storage exception. On the report strobe it samples the access type, the fault cause, the faulting effective address, the permission-check flags, the instruction and data translation enables, the hypervisor-state bit and a two-bit virtualization-mode field. From these it decides whether the fault is a fetch or a data fault, and whether it goes to the supervisor or to the hypervisor.

A data fault records its address and syndrome in one of two register pairs, one for the supervisor and one for the hypervisor. A fetch fault does not touch those registers and reports its syndrome on an error-code output instead. All results come from registers. The four status registers can be read through a small combinational read port. Table walking, translation caching and delivering the exception to the core are done elsewhere.

Top module: `mmu_fault_router`

## Requirements
- R1: A synchronous active-high `rst` clears all four status registers, `err_code`, `exc_kind` and `exc_valid`.
- R2: An accepted strobe raises `exc_valid` on the next rising edge, for exactly one cycle. All register updates become visible on that same edge.
- R3: For a fetch (`flt_acc`=2), the mode bit is chosen by `xlat_i`. When `xlat_i`=1 the bit is `part_vm[1]`; when `xlat_i`=0 it is `part_vm[0]`.
- R4: For a load (`flt_acc`=0) or a store (`flt_acc`=1), the same choice is made with `xlat_d`.
- R5: A fault goes to the hypervisor only when the chosen mode bit is 1 and `hv_mode` is 0. In every other case it goes to the supervisor, so `part_vm`=0 always gives supervisor routing.
- R6: `exc_kind` encodes the exception: 0 supervisor fetch, 1 supervisor data, 2 hypervisor fetch, 3 hypervisor data.
- R7: A data fault writes the address and syndrome into the pair it is routed to. The other pair keeps its value, and `err_code` becomes 0.
- R8: A fetch fault leaves all four status registers unchanged and puts its syndrome on `err_code`.
- R9: Fetch syndromes depend on `flt_cause`: 0 (no-execute segment) gives 0x10000000, 1 (no page entry) gives 0x40000000, 2 (protection) gives 0x08000000.
- R10: A missing page entry (`flt_cause`=1) on a load gives 0x40000000. On a store it gives 0x42000000.
- R11: A data protection fault (`flt_cause`=2) builds its syndrome from zero. It ORs in 0x08000000 when `pp_deny`=1 and 0x00200000 when `amr_deny`=1.
- R12: These strobes are ignored: `flt_acc`=3, cause 3 on any access, and cause 0 on a load or store. An ignored strobe gives no `exc_valid` and changes no status register.
- R13: `rd_sel` selects `rd_data` combinationally: 0 supervisor address, 1 supervisor syndrome, 2 hypervisor address, 3 hypervisor syndrome. Syndromes are zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_stb | input | 1 | Fault report strobe |
| flt_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 none |
| flt_cause | input | 2 | Cause: 0 no-execute, 1 no entry, 2 protection, 3 reserved |
| flt_addr | input | AW | Faulting effective address |
| pp_deny | input | 1 | Page protection rights lack the access |
| amr_deny | input | 1 | Authority mask rights lack the access |
| xlat_i | input | 1 | Instruction translation enabled |
| xlat_d | input | 1 | Data translation enabled |
| hv_mode | input | 1 | Processor already in hypervisor state |
| part_vm | input | 2 | Virtualization-mode bits of the partition control |
| rd_sel | input | 2 | Status register read select |
| rd_data | output | AW | Selected status register |
| exc_valid | output | 1 | One-cycle exception pulse |
| exc_kind | output | 2 | Exception kind |
| err_code | output | SW | Fetch syndrome, zero for data faults |

## Verification
Every result of a strobe is due one rising edge after the edge that samples it: `exc_valid`, `exc_kind`, `err_code` and the status registers all update on that single edge. The bench drives each strobe on a falling edge and reads the results on the next falling edge. Within that same low phase it walks `rd_sel` through all four values, with short delays between reads. One more falling edge later it checks that `exc_valid` has dropped again, which confirms the pulse lasted a single cycle.

// File: rtl/mmu_fault_router.sv
module mmu_fault_router #(
  parameter int AW = 64,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flt_stb,
  input  logic [1:0]    flt_acc,
  input  logic [1:0]    flt_cause,
  input  logic [AW-1:0] flt_addr,
  input  logic          pp_deny,
  input  logic          amr_deny,
  input  logic          xlat_i,
  input  logic          xlat_d,
  input  logic          hv_mode,
  input  logic [1:0]    part_vm,
  input  logic [1:0]    rd_sel,
  output logic [AW-1:0] rd_data,
  output logic          exc_valid,
  output logic [1:0]    exc_kind,
  output logic [SW-1:0] err_code
);
  localparam logic [SW-1:0] ONE      = SW'(1);
  localparam logic [SW-1:0] S_NOEXEC = ONE << (SW - 4);
  localparam logic [SW-1:0] S_NOPTE  = ONE << (SW - 2);
  localparam logic [SW-1:0] S_STORE  = ONE << (SW - 7);
  localparam logic [SW-1:0] S_PROT   = ONE << (SW - 5);
  localparam logic [SW-1:0] S_AMR    = ONE << (SW - 11);

  logic [AW-1:0] sv_addr, hv_addr;
  logic [SW-1:0] sv_syn, hv_syn, syn;

  wire is_fetch = (flt_acc == 2'd2);
  wire is_data  = ~flt_acc[1];
  wire cause_ok = is_fetch ? (flt_cause != 2'd3)
                           : (flt_cause == 2'd1 || flt_cause == 2'd2);
  wire take     = flt_stb & cause_ok & (is_fetch | is_data);
  wire xl_on    = is_fetch ? xlat_i : xlat_d;
  wire vm_bit   = xl_on ? part_vm[1] : part_vm[0];
  wire to_hv    = vm_bit & ~hv_mode;

  always_comb begin
    syn = '0;
    if (is_fetch) begin
      case (flt_cause)
        2'd0:    syn = S_NOEXEC;
        2'd1:    syn = S_NOPTE;
        2'd2:    syn = S_PROT;
        default: syn = '0;
      endcase
    end else if (flt_cause == 2'd1) begin
      syn = S_NOPTE | (flt_acc[0] ? S_STORE : '0);
    end else begin
      syn = (pp_deny ? S_PROT : '0) | (amr_deny ? S_AMR : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_valid <= 1'b0;
      exc_kind  <= '0;
      err_code  <= '0;
      sv_addr   <= '0;
      sv_syn    <= '0;
      hv_addr   <= '0;
      hv_syn    <= '0;
    end else begin
      exc_valid <= take;
      if (take) begin
        exc_kind <= {to_hv, is_data};
        err_code <= is_fetch ? syn : '0;
        if (is_data) begin
          if (to_hv) begin
            hv_addr <= flt_addr;
            hv_syn  <= syn;
          end else begin
            sv_addr <= flt_addr;
            sv_syn  <= syn;
          end
        end
      end
    end
  end

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = sv_addr;
      2'd1:    rd_data = AW'(sv_syn);
      2'd2:    rd_data = hv_addr;
      default: rd_data = AW'(hv_syn);
    endcase
  end

  a_r2_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> $past(flt_stb));

  a_r12_no_access_ignored: assert property (@(posedge clk) disable iff (rst)
    (flt_stb && flt_acc == 2'd3) |=> !exc_valid);

  a_r8_fetch_keeps_regs: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && !exc_kind[0]) |-> ($stable(sv_addr) && $stable(sv_syn) &&
                                     $stable(hv_addr) && $stable(hv_syn)));

  a_r7_data_other_pair: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && exc_kind[0]) |-> (err_code == '0 &&
      (exc_kind[1] ? ($stable(sv_addr) && $stable(sv_syn))
                   : ($stable(hv_addr) && $stable(hv_syn)))));

  a_r5_no_hv_route: assert property (@(posedge clk) disable iff (rst)
    (flt_stb && (hv_mode || part_vm == 2'b00)) |=> !(exc_valid && exc_kind[1]));

  a_r3_fetch_to_hv: assert property (@(posedge clk) disable iff (rst)
    (flt_stb && flt_acc == 2'd2 && flt_cause != 2'd3 && !hv_mode &&
     (xlat_i ? part_vm[1] : part_vm[0])) |=> (exc_valid && exc_kind == 2'd2));
endmodule

// File: tb/sim_mmu_fault_router.sv
module sim_mmu_fault_router;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 64;

  logic clk = 0, rst = 1, flt_stb = 0, pp_deny = 0, amr_deny = 0;
  logic xlat_i = 0, xlat_d = 0, hv_mode = 0;
  logic [1:0] flt_acc = 0, flt_cause = 0, part_vm = 0, rd_sel = 0;
  logic [AW-1:0] flt_addr = 0, rd_data;
  logic exc_valid;
  logic [1:0] exc_kind;
  logic [31:0] err_code;

  int checks = 0, fails = 0;
  logic [63:0] m_reg [4];

  mmu_fault_router u0 (.clk(clk), .rst(rst), .flt_stb(flt_stb), .flt_acc(flt_acc),
    .flt_cause(flt_cause), .flt_addr(flt_addr), .pp_deny(pp_deny), .amr_deny(amr_deny),
    .xlat_i(xlat_i), .xlat_d(xlat_d), .hv_mode(hv_mode), .part_vm(part_vm),
    .rd_sel(rd_sel), .rd_data(rd_data), .exc_valid(exc_valid), .exc_kind(exc_kind),
    .err_code(err_code));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit e_take(input [1:0] acc, input [1:0] cause);
    if (acc == 2'd2) return cause != 2'd3;
    if (acc == 2'd3) return 0;
    return cause == 2'd1 || cause == 2'd2;
  endfunction

  function automatic bit e_hv(input [1:0] acc, input bit xi, input bit xd,
                              input bit hv, input [1:0] vm);
    bit x = (acc == 2'd2) ? xi : xd;
    return (x ? vm[1] : vm[0]) && !hv;
  endfunction

  function automatic logic [31:0] e_syn(input [1:0] acc, input [1:0] cause,
                                        input bit pp, input bit amr);
    if (acc == 2'd2)
      return cause == 0 ? 32'h1000_0000 : cause == 1 ? 32'h4000_0000 : 32'h0800_0000;
    if (cause == 2'd1) return acc == 2'd1 ? 32'h4200_0000 : 32'h4000_0000;
    return (pp ? 32'h0800_0000 : 32'h0) | (amr ? 32'h0020_0000 : 32'h0);
  endfunction

  task automatic read_all(input string tag);
    for (int i = 0; i < 4; i++) begin
      rd_sel = 2'(i);
      #1;
      chk(rd_data === m_reg[i], tag, $sformatf("R13 status reg %0d", i), rd_data, m_reg[i]);
    end
  endtask

  task automatic apply(input [1:0] acc, input [1:0] cause, input [63:0] addr,
                       input bit pp, input bit amr, input bit xi, input bit xd,
                       input bit hv, input [1:0] vm, input string tag);
    bit tk, h;
    logic [31:0] s;
    logic [1:0] k;
    @(negedge clk);
    flt_stb = 1; flt_acc = acc; flt_cause = cause; flt_addr = addr;
    pp_deny = pp; amr_deny = amr; xlat_i = xi; xlat_d = xd; hv_mode = hv; part_vm = vm;
    @(negedge clk);
    flt_stb = 0;
    tk = e_take(acc, cause);
    h  = e_hv(acc, xi, xd, hv, vm);
    s  = e_syn(acc, cause, pp, amr);
    k  = {h, acc != 2'd2};
    if (tk) begin
      chk(exc_valid === 1'b1, "R2", "valid after strobe", 64'(exc_valid), 1);
      chk(exc_kind === k, tag, "R6 kind", 64'(exc_kind), 64'(k));
      if (acc == 2'd2) begin
        chk(err_code === s, tag, "R8 fetch err_code", 64'(err_code), 64'(s));
      end else begin
        chk(err_code === 0, tag, "R7 data err_code zero", 64'(err_code), 0);
        if (h) begin m_reg[2] = addr; m_reg[3] = 64'(s); end
        else   begin m_reg[0] = addr; m_reg[1] = 64'(s); end
      end
    end else begin
      chk(exc_valid === 1'b0, "R12", "ignored strobe valid", 64'(exc_valid), 0);
    end
    read_all(tag);
    @(negedge clk);
    chk(exc_valid === 1'b0, "R2", "single-cycle pulse", 64'(exc_valid), 0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) m_reg[i] = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(exc_valid === 0 && exc_kind === 0 && err_code === 0, "R1", "outputs after reset",
        {exc_kind, err_code}, 0);
    read_all("R1");
    // R3 fetch selection and R9 codes
    apply(2, 0, 64'h1000, 0, 0, 1, 0, 0, 2'b10, "R3");
    apply(2, 1, 64'h1004, 0, 0, 1, 0, 0, 2'b01, "R3");
    apply(2, 2, 64'h1008, 0, 0, 0, 1, 0, 2'b01, "R9");
    // R4 data selection, R10 store missing entry
    apply(1, 1, 64'hAAAA_0000_0000_1230, 0, 0, 1, 1, 0, 2'b10, "R10");
    apply(0, 1, 64'h5555_0000_0000_2000, 0, 0, 1, 0, 0, 2'b10, "R4");
    apply(0, 1, 64'h0000_0000_0000_3000, 0, 0, 0, 0, 0, 2'b01, "R4");
    // R11 protection flags
    apply(1, 2, 64'h4000, 1, 1, 0, 1, 0, 2'b00, "R11");
    apply(0, 2, 64'h4100, 0, 1, 0, 1, 0, 2'b10, "R11");
    apply(0, 2, 64'h4200, 0, 0, 0, 1, 0, 2'b10, "R11");
    // R5 hypervisor state and zero partition control
    apply(1, 1, 64'h5000, 0, 0, 1, 1, 1, 2'b11, "R5");
    apply(2, 0, 64'h5100, 0, 0, 1, 1, 1, 2'b11, "R5");
    apply(1, 1, 64'h5200, 0, 0, 1, 1, 0, 2'b00, "R5");
    // R12 ignored strobes
    apply(3, 1, 64'hDEAD, 1, 1, 1, 1, 0, 2'b11, "R12");
    apply(0, 0, 64'hBEEF, 1, 1, 1, 1, 0, 2'b11, "R12");
    apply(2, 3, 64'hCAFE, 0, 0, 1, 1, 0, 2'b11, "R12");
    // random mix
    for (int n = 0; n < 400; n++) begin
      apply(2'($urandom), 2'($urandom), {$urandom, $urandom}, 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), "R6");
    end
    // R1 reset after traffic
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int i = 0; i < 4; i++) m_reg[i] = 0;
    chk(exc_valid === 0 && exc_kind === 0 && err_code === 0, "R1", "outputs after late reset",
        {exc_kind, err_code}, 0);
    read_all("R1");
    finish_run();
  end
endmodule